// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block collects eight peripheral interrupt request lines and drives a single interrupt line towards the processor. A rising edge on a request input sets that source's pending bit. Each source can be blocked on its own by a mask bit. When the processor acknowledges, the controller picks the most urgent pending and unmasked source and marks it as in service. It then returns an 8-bit vector: a programmable base with the source number in the three low bits.

The in-service state makes nesting possible. The interrupt line rises only when a pending, unmasked source outranks every source that is already in service. Software ends a service routine with an end-of-interrupt command, which retires the most urgent in-service source. Two priority orders are available. In the fixed order, source 0 is most urgent and source 7 least. In the rotating order, the source just retired by end-of-interrupt becomes the least urgent, and the source numbered one above it becomes the most urgent.

Software reaches the controller through a small register port with a write strobe and a combinational read path, using a 2-bit address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF (all sources blocked), the vector base reads 0x00, the pending and in-service registers read 0x00, the fixed priority order is active, and `int_out` is low.
- R2: A 0-to-1 transition on `irq_req[i]` sets pending bit i on the following clock edge. A request held high sets the bit only once. Reading address 2 returns the pending bits, with bit i standing for source i.
- R3: A pending source whose mask bit is 1 neither raises `int_out` nor wins an acknowledge, and it stays pending until it is unmasked.
- R4: In the fixed order, when several unmasked sources are pending, the lowest-numbered source wins the acknowledge.
- R5: An acknowledge while `int_out` is high sets the winner's in-service bit and clears its pending bit. From the next clock edge, `vec_out` holds {base[7:3], winner index}.
- R6: `int_out` is high only when the most urgent unmasked pending source ranks strictly above the most urgent in-service source. A source of equal or lower rank waits until end-of-interrupt.
- R7: Writing address 3 (end-of-interrupt, data ignored) clears the in-service bit of the most urgent in-service source. When nothing is in service, the write has no effect.
- R8: With the rotating order enabled (address 2, data bit 0 = 1), an end-of-interrupt that retires source s makes s the least urgent and (s+1) mod 8 the most urgent. In the fixed order, end-of-interrupt leaves the order unchanged.
- R9: An acknowledge while `int_out` is low leaves the pending and in-service bits unchanged and sets `vec_out` to {base[7:3], 3'b111}.
- R10: Address map: address 0 writes and reads the mask; address 1 writes the base, and only bits 7:3 are kept (bits 2:0 read as 0); address 2 writes the order select (bit 0) and reads the pending bits; address 3 writes end-of-interrupt and reads the in-service bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Peripheral request lines, edge detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| int_ack | input | 1 | Processor acknowledge, one cycle per acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned by the last acknowledge |

## Verification
The hardest situation to reach is rotation after a full retirement sequence. The least-urgent pointer only moves on end-of-interrupt, so checking every rotated order requires driving the pointer to each of the eight positions first. The stimulus does this by serving a single source s and then retiring it. It then raises all eight lines at once and drains them one by one, expecting s+1, s+2 and onward in turn. Nesting is reached by serving one source of every ordered pair and then raising the other. This checks that the interrupt line follows strict rank, and that end-of-interrupt retires the more urgent of the two sources.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Source count must stay a power of two: rank arithmetic wraps on IDX_W bits
    localparam int N_SRC  = 8;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int BASE_W = DATA_W - IDX_W;
    localparam int RANK_W = IDX_W + 1;

    typedef logic [N_SRC-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0]  src_idx_t;
    typedef logic [RANK_W-1:0] rank_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_ORDER = 2'd2,
        SEL_RETIRE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ORDER_FIXED  = 1'b0,
        ORDER_ROTATE = 1'b1
    } order_e;

    typedef struct packed {
        logic     hit;
        src_idx_t idx;
        rank_t    rank;
    } pick_t;

    localparam rank_t RANK_NONE = rank_t'(N_SRC);

    // Source that holds a given rank when 'low' is the least urgent source
    function automatic src_idx_t rank_to_idx(src_idx_t low, src_idx_t rank);
        return low + src_idx_t'(1) + rank;
    endfunction
endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
    import irqc_pkg::*;
(
    input  src_vec_t cand,
    input  src_idx_t low,
    output pick_t    pick
);
    src_idx_t probe;

    always_comb begin
        pick.hit  = 1'b0;
        pick.idx  = '0;
        pick.rank = RANK_NONE;
        probe     = '0;
        // walk from least to most urgent so the most urgent hit is kept
        for (int k = N_SRC - 1; k >= 0; k--) begin
            probe = rank_to_idx(low, src_idx_t'(k));
            if (cand[probe]) begin
                pick.hit  = 1'b1;
                pick.idx  = probe;
                pick.rank = rank_t'(k);
            end
        end
    end
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t req_in,
    input  src_vec_t clr,
    output src_vec_t pend
);
    src_vec_t req_q;
    src_vec_t rise;

    assign rise = req_in & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req_in;
            pend  <= (pend & ~clr) | rise;
        end
    end

    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~rise) != '0) |=> ((pend & $past(clr & ~rise)) == '0)); // R5

    AST_HELD_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (((req_in & req_q & ~pend) != '0) && (clr == '0)) |=>
            ((pend & $past(req_in & req_q & ~pend)) == '0)); // R2
endmodule

// File: rtl/irqc_service.sv
module irqc_service
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack_go,
    input  src_idx_t ack_idx,
    input  logic     retire,
    input  order_e   order,
    output src_vec_t isr,
    output pick_t    isr_pick,
    output src_idx_t eff_low
);
    src_idx_t rot_low;
    src_vec_t isr_n;

    assign eff_low = (order == ORDER_ROTATE) ? rot_low : src_idx_t'(N_SRC - 1);

    irqc_prio_pick u_isr_pick (
        .cand (isr),
        .low  (eff_low),
        .pick (isr_pick)
    );

    always_comb begin
        isr_n = isr;
        if (retire && isr_pick.hit) isr_n[isr_pick.idx] = 1'b0;
        if (ack_go)                 isr_n[ack_idx]      = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            rot_low <= src_idx_t'(N_SRC - 1);
        end else begin
            isr <= isr_n;
            if (retire && isr_pick.hit && order == ORDER_ROTATE)
                rot_low <= isr_pick.idx;
        end
    end

    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (rst)
        ack_go |=> isr[$past(ack_idx)]); // R5

    AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (rst)
        (retire && isr_pick.hit && !ack_go) |=>
            ($countones(isr) == $countones($past(isr)) - 1)); // R7

    AST_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (retire && isr == '0 && !ack_go) |=> (isr == '0)); // R7

    AST_FIXED_KEEPS_ORDER: assert property (@(posedge clk) disable iff (rst)
        (order == ORDER_FIXED) |-> (eff_low == src_idx_t'(N_SRC - 1))); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              int_ack,
    output logic              int_out,
    output logic [DATA_W-1:0] vec_out
);
    src_vec_t          mask_q;
    logic [BASE_W-1:0] base_q;
    order_e            order_q;
    src_vec_t          pend;
    src_vec_t          isr;
    src_vec_t          ack_clr;
    pick_t             req_pick;
    pick_t             isr_pick;
    src_idx_t          eff_low;
    logic              retire;
    logic              ack_go;
    reg_sel_e          wsel;
    reg_sel_e          rsel;

    assign wsel   = reg_sel_e'(wr_addr);
    assign rsel   = reg_sel_e'(rd_addr);
    assign retire = wr_en && (wsel == SEL_RETIRE);

    // register port
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            base_q  <= '0;
            order_q <= ORDER_FIXED;
        end else if (wr_en) begin
            case (wsel)
                SEL_MASK:  mask_q  <= wr_data[N_SRC-1:0];
                SEL_BASE:  base_q  <= wr_data[DATA_W-1:IDX_W];
                SEL_ORDER: order_q <= order_e'(wr_data[0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rsel)
            SEL_MASK:  rd_data = DATA_W'(mask_q);
            SEL_BASE:  rd_data = {base_q, {IDX_W{1'b0}}};
            SEL_ORDER: rd_data = DATA_W'(pend);
            default:   rd_data = DATA_W'(isr);
        endcase
    end

    irqc_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .req_in (irq_req),
        .clr    (ack_clr),
        .pend   (pend)
    );

    irqc_prio_pick u_req_pick (
        .cand (pend & ~mask_q),
        .low  (eff_low),
        .pick (req_pick)
    );

    irqc_service u_service (
        .clk      (clk),
        .rst      (rst),
        .ack_go   (ack_go),
        .ack_idx  (req_pick.idx),
        .retire   (retire),
        .order    (order_q),
        .isr      (isr),
        .isr_pick (isr_pick),
        .eff_low  (eff_low)
    );

    assign int_out = req_pick.hit && (req_pick.rank < isr_pick.rank);
    assign ack_go  = int_ack && int_out;
    assign ack_clr = ack_go ? (src_vec_t'(1) << req_pick.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out <= '0;
        end else if (int_ack) begin
            vec_out <= {base_q, ack_go ? req_pick.idx : {IDX_W{1'b1}}};
        end
    end

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((pend & ~mask_q) != '0)); // R3

    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> (vec_out[DATA_W-1:IDX_W] == $past(base_q))); // R5

    AST_SPURIOUS_STILL: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_out && !retire) |=> ($stable(isr) && vec_out[IDX_W-1:0] == '1)); // R9

    AST_NEST_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (isr != '0 && (pend & ~mask_q) == '0) |-> !int_out); // R6
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_req = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       int_ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .int_ack (int_ack),
        .int_out (int_out),
        .vec_out (vec_out)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic [7:0] m);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
    endtask

    task automatic ack(output logic [7:0] v);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        v = vec_out;
    endtask

    task automatic retire();
        wr(2'd3, 8'h00);
    endtask

    localparam logic [7:0] BASE = 8'hA0;

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        rd(2'd0, d); chk("R1 mask", d, 8'hFF);
        rd(2'd1, d); chk("R1 base", d, 8'h00);
        rd(2'd2, d); chk("R1 pending", d, 8'h00);
        rd(2'd3, d); chk("R1 isr", d, 8'h00);

        // R10 register map
        wr(2'd1, 8'hA5); rd(2'd1, d); chk("R10 base low bits dropped", d, BASE);
        wr(2'd0, 8'h3C); rd(2'd0, d); chk("R10 mask readback", d, 8'h3C);
        wr(2'd0, 8'hFF);

        // R2/R3/R9 masked source
        pulse(8'h01);
        chk("R3 masked no int", {7'd0, int_out}, 8'h00);
        rd(2'd2, d); chk("R2 pending set", d, 8'h01);
        ack(v);
        chk("R9 spurious vector", v, BASE | 8'h07);
        rd(2'd3, d); chk("R9 isr unchanged", d, 8'h00);
        rd(2'd2, d); chk("R3 still pending", d, 8'h01);
        wr(2'd0, 8'h00);
        chk("R3 unmask raises int", {7'd0, int_out}, 8'h01);
        ack(v);
        chk("R5 vector", v, BASE);
        rd(2'd3, d); chk("R5 isr set", d, 8'h01);
        rd(2'd2, d); chk("R5 pending cleared", d, 8'h00);
        retire();
        rd(2'd3, d); chk("R7 retire", d, 8'h00);
        retire();
        rd(2'd3, d); chk("R7 retire empty", d, 8'h00);

        // R2 held level sets once
        irq_req = 8'h10;
        @(negedge clk); @(negedge clk);
        ack(v); chk("R2 held vector", v, BASE | 8'h04);
        @(negedge clk);
        rd(2'd2, d); chk("R2 held no re-set", d, 8'h00);
        retire();
        chk("R2 held no int", {7'd0, int_out}, 8'h00);
        irq_req = 8'h00;
        @(negedge clk);

        // R5 single source sweep
        for (int i = 0; i < 8; i++) begin
            pulse(8'(1 << i));
            chk("R5 single int", {7'd0, int_out}, 8'h01);
            ack(v); chk("R5 single vector", v, BASE | 8'(i));
            rd(2'd3, d); chk("R5 single isr", d, 8'(1 << i));
            retire();
            rd(2'd3, d); chk("R7 single retire", d, 8'h00);
        end

        // R6 nesting over all ordered pairs
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a == b) continue;
                pulse(8'(1 << a));
                ack(v); chk("R6 first vector", v, BASE | 8'(a));
                pulse(8'(1 << b));
                chk("R6 preempt", {7'd0, int_out}, (b < a) ? 8'h01 : 8'h00);
                if (b < a) begin
                    ack(v); chk("R6 nested vector", v, BASE | 8'(b));
                    rd(2'd3, d); chk("R6 nested isr", d, 8'((1 << a) | (1 << b)));
                    retire();
                    rd(2'd3, d); chk("R7 retires most urgent", d, 8'(1 << a));
                    retire();
                end else begin
                    retire();
                    chk("R6 released after retire", {7'd0, int_out}, 8'h01);
                    ack(v); chk("R6 deferred vector", v, BASE | 8'(b));
                    retire();
                end
                rd(2'd3, d); chk("R6 clean isr", d, 8'h00);
            end
        end

        // R4 every simultaneous pattern, fixed order
        for (int p = 1; p < 256; p++) begin
            pulse(8'(p));
            for (int k = 0; k < 8; k++) begin
                if (p[k]) begin
                    ack(v); chk("R4 fixed order", v, BASE | 8'(k));
                    retire();
                end
            end
            rd(2'd2, d); chk("R4 drained", d, 8'h00);
        end

        // R8 rotating order
        wr(2'd2, 8'h01);
        for (int s = 0; s < 8; s++) begin
            pulse(8'(1 << s));
            ack(v); chk("R8 seed vector", v, BASE | 8'(s));
            retire();
            pulse(8'hFF);
            for (int k = 1; k <= 8; k++) begin
                ack(v); chk("R8 rotated order", v, BASE | 8'((s + k) % 8));
                retire();
            end
            rd(2'd2, d); chk("R8 drained", d, 8'h00);
        end

        // R8 back to fixed order
        wr(2'd2, 8'h00);
        pulse(8'h81);
        ack(v); chk("R8 fixed restored", v, BASE);
        retire();
        ack(v); chk("R8 fixed second", v, BASE | 8'h07);
        retire();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule